// File: doc/BRIEF.md
# Bridge-Sensor ADC Serial Readout Engine

This block reads one sample from an external 24-bit bridge-sensor converter over a two-wire link. One wire is a serial clock that the block drives; holding that clock high for too long puts the converter into power-down and reset. The other wire is the converter's data line, which the block samples. When the data line is low, a conversion is ready. The block then shifts in 24 bits, adds one to three trailing clock pulses, and returns the word in offset-binary form. The trailing pulses tell the converter which input channel and which gain to use for its next conversion.

A read request is accepted through a valid/ready handshake, and `req_mode` is captured along with it. `req_ready` is high only while the engine is idle. A request offered while a read is in progress is not accepted and leaves no trace. The result leaves the block as a one-cycle strobe with no back-pressure: the consumer must take `res_data` and `res_err` in the cycle `res_valid` is high. The length of each clock phase is fixed at elaboration. It equals one period of the configured link frequency, counted in system clock cycles.

Top module: `bridge_adc_reader`

## Requirements
- R1: After reset, `adc_sck` is low, `res_valid` is low and `req_ready` is high. `adc_sck` stays low whenever the engine is idle.
- R2: If the synchronised data line is high in the cycle a request is accepted, the next cycle carries `res_valid` with `res_err`=1 and `res_data`=0, and no clock pulse is issued.
- R3: A successful read captures exactly 24 data bits, most significant bit first. Each bit is sampled at the end of the low phase that follows a clock high phase.
- R4: Every clock pulse is high for exactly HALF system cycles and then low for exactly HALF system cycles.
- R5: HALF = CLK_HZ / SCK_HZ. A SCK_HZ below 20 000 is replaced by 400 000. With CLK_HZ = 125 MHz this gives 50 cycles at 2.5 MHz and 312 cycles at 10 kHz.
- R6: After the 24 data pulses, trailing pulses follow according to `req_mode`: 0 gives 1 pulse (channel A, gain 128), 1 gives 2 pulses (channel B, gain 32), 2 gives 3 pulses (channel A, gain 64), and 3 gives 1 pulse.
- R7: `res_data` is the captured word with bit 23 inverted, and `res_err` is 0, for a successful read.
- R8: A request made while a read is in progress is ignored. It causes no extra clock pulse, no extra result and no change to the trailing-pulse count of the running read.
- R9: The clock is never high for 60 µs or longer.
- R10: `res_valid` is high for exactly one cycle per successful read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Engine idle; a request is accepted |
| req_mode | input | 2 | Channel/gain selection for the next conversion |
| adc_sck | output | 1 | Serial clock and power-down control to the converter |
| adc_dout | input | 1 | Converter data line (asynchronous) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Offset-binary result |
| res_err | output | 1 | Converter was not ready at request |

## Verification
A wrong pulse counter shows up as a wrong number of clock rising edges per read. It also lands the result strobe off by a whole pulse period, about 2·HALF cycles, from where it belongs. A wrong phase timer shows up in the first high phase, within HALF cycles of the request. A fault in the shift path or the sign inversion appears in the single `res_data` word of that same read. A fault in the ready check appears within two cycles of an error request, as a clock pulse or a missing `res_err`.

// File: rtl/badc_pkg.sv
package badc_pkg;
  localparam int unsigned DATA_W    = 24;
  localparam int unsigned MAX_TRAIL = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW} seq_state_t;

  // trailing pulses after the data word select the next conversion
  function automatic logic [1:0] trail_pulses(input logic [1:0] mode);
    case (mode)
      2'd1:    return 2'd2;
      2'd2:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/badc_sync.sv
module badc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/badc_phase_timer.sv
module badc_phase_timer #(
  parameter int unsigned HALF = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
endmodule

// File: rtl/badc_seq.sv
module badc_seq
  import badc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  output logic              req_ready,
  input  logic              din_s,
  input  logic              tick,
  output logic              run,
  output logic              sck,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  localparam int unsigned PW = $clog2(DATA_W + MAX_TRAIL + 1);
  localparam logic [DATA_W-1:0] SIGN_FLIP = DATA_W'(1) << (DATA_W - 1);

  seq_state_t        state;
  logic [PW-1:0]     pcnt, ptot;
  logic [DATA_W-1:0] shreg;
  logic              accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign run       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sck       <= 1'b0;
      pcnt      <= '0;
      ptot      <= '0;
      shreg     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (din_s) begin
            res_valid <= 1'b1;
            res_err   <= 1'b1;
            res_data  <= '0;
          end else begin
            state <= ST_HIGH;
            sck   <= 1'b1;
            pcnt  <= '0;
            ptot  <= PW'(DATA_W) + PW'(trail_pulses(req_mode));
          end
        end
        ST_HIGH: if (tick) begin
          sck   <= 1'b0;
          state <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          if (pcnt < PW'(DATA_W)) shreg <= {shreg[DATA_W-2:0], din_s};
          if (pcnt == ptot - 1'b1) begin
            state     <= ST_IDLE;
            res_valid <= 1'b1;
            res_err   <= 1'b0;
            res_data  <= shreg ^ SIGN_FLIP;
          end else begin
            pcnt  <= pcnt + 1'b1;
            sck   <= 1'b1;
            state <= ST_HIGH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_sck_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !$past(run)) |-> !sck);

  p_err_no_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && din_s) |=> (!sck && res_err && res_valid));

  p_busy_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && req_valid) |=> $stable(ptot));
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader
  import badc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned SCK_HZ = 400_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_mode,
  output logic        adc_sck,
  input  logic        adc_dout,
  output logic        res_valid,
  output logic [23:0] res_data,
  output logic        res_err
);
  localparam int unsigned FALLBACK_HZ = 400_000;
  localparam int unsigned MIN_HZ      = 20_000;
  localparam int unsigned EFF_HZ      = (SCK_HZ < MIN_HZ) ? FALLBACK_HZ : SCK_HZ;
  localparam int unsigned HALF        = CLK_HZ / EFF_HZ;
  localparam int unsigned HIGH_LIMIT  = (CLK_HZ / 1_000_000) * 60;
  localparam int unsigned HW          = $clog2(HIGH_LIMIT + 2);

  logic din_s, tick, run;

  badc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_dout), .q(din_s)
  );

  badc_phase_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  badc_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode), .req_ready(req_ready),
    .din_s(din_s), .tick(tick), .run(run), .sck(adc_sck),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  // high-time monitor for the power-down threshold
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hi_run <= '0;
    else if (adc_sck) hi_run <= hi_run + 1'b1;
    else              hi_run <= '0;

  p_high_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sck) |-> (hi_run == HW'(HALF)));

  p_high_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck |-> (hi_run < HW'(HIGH_LIMIT)));

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |=> !res_valid);
endmodule

// File: tb/sim_bridge_adc_reader.sv
`timescale 1ns/1ps
module sim_bridge_adc_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_mode  = 2'd0;
  logic        adc_sck, adc_dout, res_valid, res_err;
  logic [23:0] res_data;

  logic        req1 = 1'b0, ready1, sck1, valid1, err1;
  logic [23:0] data1;

  bridge_adc_reader #(.CLK_HZ(125_000_000), .SCK_HZ(2_500_000)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .adc_sck(adc_sck), .adc_dout(adc_dout),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  bridge_adc_reader #(.CLK_HZ(125_000_000), .SCK_HZ(10_000)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req1), .req_ready(ready1),
    .req_mode(2'd0), .adc_sck(sck1), .adc_dout(1'b0),
    .res_valid(valid1), .res_data(data1), .res_err(err1)
  );

  // converter model: bit k-1 presented after the k-th rising edge
  int          total_rises = 0;
  int          base = 0;
  int          k;
  logic [23:0] word = '0;
  logic        force_hi = 1'b0;
  logic        mb;
  always @(posedge adc_sck) total_rises <= total_rises + 1;
  always_comb begin
    k = total_rises - base;
    if (k <= 0)       mb = 1'b0;
    else if (k >= 25) mb = 1'b1;
    else              mb = word[24-k];
  end
  assign adc_dout = force_hi | mb;

  int nres = 0;
  always @(posedge clk) if (res_valid) nres <= nres + 1;

  int vectors = 0, miscompares = 0;
  logic [23:0] got_data;
  logic        got_err;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [23:0] w, input logic hi);
    word = w; force_hi = hi; base = total_rises;
    repeat (4) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] m);
    @(negedge clk); req_mode = m; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!res_valid && n < 40000) begin @(negedge clk); n++; end
    got_data = res_data; got_err = res_err;
    @(negedge clk);
    check(!res_valid, "R10 strobe width", int'(res_valid), 0);
  endtask

  function automatic int trail(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 3 : 1;
  endfunction

  task automatic t_read(input logic [1:0] m, input logic [23:0] w);
    arm(w, 1'b0);
    issue(m);
    wait_result();
    check(got_data == (w ^ 24'h800000), "R3/R7 data", int'(got_data), int'(w ^ 24'h800000));
    check(!got_err, "R7 err clear", int'(got_err), 0);
    check(total_rises - base == 24 + trail(m), "R6 pulse count", total_rises - base, 24 + trail(m));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready && !adc_sck && !res_valid, "R1 reset state",
          {req_ready, adc_sck, res_valid}, 3'b100);
  endtask

  task automatic t_square();
    int hi = 0, lo = 0;
    arm(24'hA5A5A5, 1'b0);
    issue(2'd0);
    while (!adc_sck) @(negedge clk);
    while (adc_sck) begin hi++; @(negedge clk); end
    while (!adc_sck) begin lo++; @(negedge clk); end
    check(hi == 50, "R4 high phase", hi, 50);
    check(lo == 50, "R4 low phase", lo, 50);
    check(hi * 8 < 60000, "R9 high time", hi * 8, 60000);
    wait_result();
    check(got_data == 24'h25A5A5, "R3 data", int'(got_data), 24'h25A5A5);
  endtask

  task automatic t_not_ready();
    int r0, v0;
    arm(24'h0F0F0F, 1'b1);
    r0 = total_rises; v0 = nres;
    issue(2'd1);
    wait_result();
    check(got_err, "R2 error flag", int'(got_err), 1);
    check(got_data == 0, "R2 data zero", int'(got_data), 0);
    repeat (200) @(negedge clk);
    check(total_rises == r0, "R2 no pulses", total_rises - r0, 0);
    check(nres == v0 + 1, "R2 one result", nres - v0, 1);
    force_hi = 1'b0;
  endtask

  task automatic t_busy();
    int v0;
    arm(24'h3C3C3C, 1'b0);
    v0 = nres;
    issue(2'd0);
    repeat (300) @(negedge clk);
    check(!req_ready, "R8 busy not ready", int'(req_ready), 0);
    req_mode = 2'd2; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_result();
    check(got_data == 24'hBC3C3C, "R8 data", int'(got_data), 24'hBC3C3C);
    check(total_rises - base == 25, "R8 pulse count", total_rises - base, 25);
    repeat (400) @(negedge clk);
    check(total_rises - base == 25, "R8 no extra pulses", total_rises - base, 25);
    check(nres == v0 + 1, "R8 one result", nres - v0, 1);
  endtask

  task automatic t_fallback();
    int hi = 0;
    @(negedge clk); req1 = 1'b1;
    @(negedge clk); req1 = 1'b0;
    while (!sck1) @(negedge clk);
    while (sck1) begin hi++; @(negedge clk); end
    check(hi == 312, "R5 fallback half period", hi, 312);
    check(hi * 8 < 60000, "R9 fallback high time", hi * 8, 60000);
  endtask

  initial begin
    #(150000 * 8);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(2'd0, 24'h123456);
    t_read(2'd1, 24'hFEDCBA);
    t_read(2'd2, 24'h800000);
    t_read(2'd3, 24'h7FFFFF);
    t_square();
    t_not_ready();
    t_busy();
    t_read(2'd2, 24'h000001);
    t_fallback();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule